// File: doc/BRIEF.md
# Packed-Pixel Random-Access Iterator

This block stands between a processing algorithm and a byte-wide RAM holding a vector of pixels. The algorithm sees only a position and a set of single-cycle commands: step forward, step back, jump to a position, fetch the current element and store to the current element. The iterator alone drives the memory port, so the algorithm never learns how the container is laid out in memory.

Each logical element is wider than the memory data bus. With the default settings a 24-bit pixel is stored as three bytes. The iterator turns one element fetch or store into a train of byte accesses on consecutive cycles. For a fetch it collects the returned bytes into a registered pixel, and for a store it hands out the bytes of a latched pixel. It pulses a completion flag when the transaction has finished. While a transaction is in flight the iterator reports itself busy and disregards every command.

Top module: `pix_iter`

## Requirements
- R1: After reset the position is 0, busy_o, done_o and mem_en_o are low and rdata_o is all zeros.
- R2: When idle, inc_i alone advances the position by one and wraps from ELEM_COUNT-1 to 0; dec_i alone steps back by one and wraps from 0 to ELEM_COUNT-1.
- R3: When idle, idx_i loads idx_pos_i, clipped to ELEM_COUNT-1. idx_i takes precedence over inc_i and dec_i. inc_i and dec_i asserted together without idx_i leave the position unchanged.
- R4: While busy_o is high every command input is ignored: the position does not move and no further memory transaction or done pulse results.
- R5: A read or write accepted at a clock edge issues exactly BYTES_PER_ELEM memory beats on the following consecutive cycles. Beat k uses address p*BYTES_PER_ELEM+k, where p is the position held before any move accepted at that same edge.
- R6: Byte order: beat 0 carries element bits [23:16] (red), beat 1 carries bits [15:8] (green) and beat 2 carries bits [7:0] (blue).
- R7: done_o is high for exactly one cycle. That cycle comes two cycles after the last beat, and busy_o is already low in it.
- R8: rdata_o changes only in the done cycle of a read and holds its value through writes and idle periods.
- R9: If rd_i and wr_i are asserted together, a read is performed and memory is not written.
- R10: mem_we_o is high only during the beats of a write; mem_en_o is low whenever no beat is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_i | input | 1 | Step position forward |
| dec_i | input | 1 | Step position backward |
| rd_i | input | 1 | Fetch element at current position |
| wr_i | input | 1 | Store wdata_i at current position |
| idx_i | input | 1 | Load position from idx_pos_i |
| idx_pos_i | input | POS_W | Target position for idx_i |
| wdata_i | input | ELEM_W | Element to store |
| rdata_o | output | ELEM_W | Last fetched element |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Transaction in flight |
| pos_o | output | POS_W | Current position |
| mem_en_o | output | 1 | Memory beat enable |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | BYTE_W | Byte to memory |
| mem_rdata_i | input | BYTE_W | Byte from memory, one cycle after a read beat |

## Verification
The hardest case to reach is a transaction combined with a move in the same accepting cycle, followed by commands raised while busy. The point is to show that the beats use the old position and that the new position survives the busy window. The stimulus sends a fetch together with an increment and samples the address on each beat cycle. It then holds jump, step, read and write asserted for the whole busy window of a store. Afterwards it counts done pulses and reads the position and the memory bytes back.

// File: rtl/pix_iter_pkg.sv
package pix_iter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_TAIL = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pix_iter_pos.sv
module pix_iter_pos #(
  parameter int ELEM_COUNT = 12,
  parameter int POS_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             idx_i,
  input  logic [POS_W-1:0] idx_pos_i,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(ELEM_COUNT - 1);

  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (idx_i)
      pos_d = (idx_pos_i > LAST) ? LAST : idx_pos_i;
    else if (inc_i && !dec_i)
      pos_d = (pos_q == LAST) ? '0 : pos_q + 1'b1;
    else if (dec_i && !inc_i)
      pos_d = (pos_q == '0) ? LAST : pos_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pos_q <= '0;
    else if (accept_i) pos_q <= pos_d;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/pix_iter_seq.sv
module pix_iter_seq
  import pix_iter_pkg::*;
#(
  parameter int BYTES  = 3,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              is_rd_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic              cap_en_o,
  output logic [BEAT_W-1:0] cap_idx_o,
  output logic              commit_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BYTES - 1);

  seq_state_e        state_q;
  logic [BEAT_W-1:0] beat_q;
  logic              rd_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_BEAT;
          beat_q  <= '0;
          rd_q    <= is_rd_i;
        end
        ST_BEAT: begin
          if (beat_q == LAST_BEAT) state_q <= ST_TAIL;
          else                     beat_q  <= beat_q + 1'b1;
        end
        ST_TAIL: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // read data lags each beat by one cycle
  assign beat_o    = beat_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign mem_en_o  = (state_q == ST_BEAT);
  assign mem_we_o  = (state_q == ST_BEAT) && !rd_q;
  assign cap_en_o  = rd_q && (((state_q == ST_BEAT) && (beat_q != '0)) || (state_q == ST_TAIL));
  assign cap_idx_o = (state_q == ST_TAIL) ? LAST_BEAT : beat_q - 1'b1;
  assign commit_o  = rd_q && (state_q == ST_TAIL);
endmodule

// File: rtl/pix_iter_pack.sv
module pix_iter_pack #(
  parameter int BYTES  = 3,
  parameter int BYTE_W = 8,
  parameter int BEAT_W = 2,
  parameter int ELEM_W = BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ELEM_W-1:0] wdata_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              cap_en_i,
  input  logic [BEAT_W-1:0] cap_idx_i,
  input  logic              commit_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic [ELEM_W-1:0] rdata_o
);
  logic [ELEM_W-1:0] wdata_q, rdata_q, gathered;
  logic [BYTES-2:0][BYTE_W-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wdata_q <= '0;
    else if (load_i) wdata_q <= wdata_i;
  end

  // beat 0 is the most significant byte
  always_comb begin
    mem_wdata_o = '0;
    for (int k = 0; k < BYTES; k++)
      if (beat_i == BEAT_W'(k))
        mem_wdata_o = wdata_q[ELEM_W-1-k*BYTE_W -: BYTE_W];
  end

  for (genvar g = 0; g < BYTES - 1; g++) begin : g_shadow
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        shadow_q[g] <= '0;
      else if (cap_en_i && cap_idx_i == BEAT_W'(g))
        shadow_q[g] <= mem_rdata_i;
    end
    assign gathered[ELEM_W-1-g*BYTE_W -: BYTE_W] = shadow_q[g];
  end
  assign gathered[BYTE_W-1:0] = mem_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (commit_i) rdata_q <= gathered;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pix_iter.sv
module pix_iter #(
  parameter int ELEM_COUNT     = 12,
  parameter int BYTES_PER_ELEM = 3,
  parameter int BYTE_W         = 8,
  localparam int POS_W  = (ELEM_COUNT > 1) ? $clog2(ELEM_COUNT) : 1,
  localparam int ELEM_W = BYTES_PER_ELEM * BYTE_W,
  localparam int ADDR_W = $clog2(ELEM_COUNT * BYTES_PER_ELEM),
  localparam int BEAT_W = $clog2(BYTES_PER_ELEM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              dec_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              idx_i,
  input  logic [POS_W-1:0]  idx_pos_i,
  input  logic [ELEM_W-1:0] wdata_i,
  output logic [ELEM_W-1:0] rdata_o,
  output logic              done_o,
  output logic              busy_o,
  output logic [POS_W-1:0]  pos_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  logic              accept, start;
  logic [POS_W-1:0]  pos, base_q;
  logic [BEAT_W-1:0] beat, cap_idx;
  logic              cap_en, commit;

  assign accept = !busy_o;
  assign start  = accept && (rd_i || wr_i);

  pix_iter_pos #(.ELEM_COUNT(ELEM_COUNT), .POS_W(POS_W)) u_pos (
    .clk_i, .rst_ni,
    .accept_i  (accept),
    .inc_i, .dec_i, .idx_i, .idx_pos_i,
    .pos_o     (pos)
  );

  // access uses the position from before a same-edge move
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    base_q <= '0;
    else if (start) base_q <= pos;
  end

  pix_iter_seq #(.BYTES(BYTES_PER_ELEM), .BEAT_W(BEAT_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i   (start),
    .is_rd_i   (rd_i),
    .beat_o    (beat),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .mem_en_o  (mem_en_o),
    .mem_we_o  (mem_we_o),
    .cap_en_o  (cap_en),
    .cap_idx_o (cap_idx),
    .commit_o  (commit)
  );

  pix_iter_pack #(.BYTES(BYTES_PER_ELEM), .BYTE_W(BYTE_W), .BEAT_W(BEAT_W)) u_pack (
    .clk_i, .rst_ni,
    .load_i      (start),
    .wdata_i     (wdata_i),
    .beat_i      (beat),
    .cap_en_i    (cap_en),
    .cap_idx_i   (cap_idx),
    .commit_i    (commit),
    .mem_rdata_i (mem_rdata_i),
    .mem_wdata_o (mem_wdata_o),
    .rdata_o     (rdata_o)
  );

  assign mem_addr_o = ADDR_W'(base_q) * ADDR_W'(BYTES_PER_ELEM) + ADDR_W'(beat);
  assign pos_o      = pos;
endmodule

// File: rtl/pix_iter_chk.sv
module pix_iter_chk #(
  parameter int ELEM_COUNT     = 12,
  parameter int BYTES_PER_ELEM = 3,
  parameter int POS_W          = 4,
  parameter int ELEM_W         = 24,
  parameter int ADDR_W         = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [POS_W-1:0]  pos_o,
  input logic [ELEM_W-1:0] rdata_o,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  AST_POS_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pos_o) < ELEM_COUNT); // R3
  AST_POS_FROZEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(pos_o)); // R4
  AST_ADDR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> int'(mem_addr_o) < ELEM_COUNT * BYTES_PER_ELEM); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R7
  AST_DONE_AFTER_BEATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_en_o) |=> done_o); // R7
  AST_RDATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rdata_o)); // R8
  AST_WE_IN_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_en_o && busy_o)); // R10
endmodule

bind pix_iter pix_iter_chk #(
  .ELEM_COUNT(ELEM_COUNT), .BYTES_PER_ELEM(BYTES_PER_ELEM),
  .POS_W(POS_W), .ELEM_W(ELEM_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .pos_o(pos_o), .rdata_o(rdata_o), .mem_en_o(mem_en_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o)
);

// File: tb/pix_iter_test.sv
`timescale 1ns/1ps
module pix_iter_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        inc_i = 0, dec_i = 0, rd_i = 0, wr_i = 0, idx_i = 0;
  logic [3:0]  idx_pos_i = '0;
  logic [23:0] wdata_i = '0, rdata_o;
  logic        done_o, busy_o, mem_en_o, mem_we_o;
  logic [3:0]  pos_o;
  logic [5:0]  mem_addr_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i;
  logic [7:0]  bmem [0:63];
  int n_chk = 0, n_bad = 0, n_done = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  pix_iter uut (.*);

  always @(posedge clk_i)
    if (mem_en_o) begin
      if (mem_we_o) bmem[mem_addr_o] <= mem_wdata_o;
      else          mem_rdata_i <= bmem[mem_addr_o];
    end

  always @(negedge clk_i) if (rst_ni && done_o) n_done++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(input bit inc, input bit dec, input bit rd, input bit wr,
                     input bit idx, input int p, input logic [23:0] wd);
    inc_i = inc; dec_i = dec; rd_i = rd; wr_i = wr; idx_i = idx;
    idx_pos_i = 4'(p); wdata_i = wd;
    @(negedge clk_i);
    inc_i = 0; dec_i = 0; rd_i = 0; wr_i = 0; idx_i = 0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done_o && n < 20) begin @(negedge clk_i); n++; end
    chk(done_o, req, 32'(done_o), 1);
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk(pos_o == 0, "R1 pos", 32'(pos_o), 0);
    chk(!busy_o && !done_o, "R1 busy/done", 32'({busy_o, done_o}), 0);
    chk(!mem_en_o, "R1 mem_en", 32'(mem_en_o), 0);
    chk(rdata_o == 0, "R1 rdata", 32'(rdata_o), 0);
  endtask

  task automatic t_moves;
    cmd(0, 1, 0, 0, 0, 0, 0); chk(pos_o == 11, "R2 dec wrap", 32'(pos_o), 11);
    cmd(1, 0, 0, 0, 0, 0, 0); chk(pos_o == 0, "R2 inc wrap", 32'(pos_o), 0);
    cmd(1, 0, 0, 0, 0, 0, 0); cmd(1, 0, 0, 0, 0, 0, 0); cmd(1, 0, 0, 0, 0, 0, 0);
    chk(pos_o == 3, "R2 inc", 32'(pos_o), 3);
    cmd(0, 1, 0, 0, 0, 0, 0); chk(pos_o == 2, "R2 dec", 32'(pos_o), 2);
    cmd(0, 0, 0, 0, 1, 5, 0); chk(pos_o == 5, "R3 index", 32'(pos_o), 5);
    cmd(0, 0, 0, 0, 1, 13, 0); chk(pos_o == 11, "R3 clip", 32'(pos_o), 11);
    cmd(1, 0, 0, 0, 1, 2, 0); chk(pos_o == 2, "R3 idx over inc", 32'(pos_o), 2);
    cmd(1, 1, 0, 0, 0, 0, 0); chk(pos_o == 2, "R3 inc+dec", 32'(pos_o), 2);
  endtask

  task automatic t_write_read;
    cmd(0, 0, 0, 0, 1, 4, 0);
    cmd(0, 0, 0, 1, 0, 0, 24'hA1B2C3); wait_done("R5 write done");
    chk(bmem[12] == 8'hA1, "R6 red byte", 32'(bmem[12]), 'hA1);
    chk(bmem[13] == 8'hB2, "R6 green byte", 32'(bmem[13]), 'hB2);
    chk(bmem[14] == 8'hC3, "R6 blue byte", 32'(bmem[14]), 'hC3);
    cmd(0, 0, 1, 0, 0, 0, 0); wait_done("R5 read done");
    chk(rdata_o == 24'hA1B2C3, "R6 read assemble", 32'(rdata_o), 'hA1B2C3);
    cmd(0, 0, 0, 0, 1, 11, 0);
    cmd(0, 0, 0, 1, 0, 0, 24'h010203); wait_done("R5 write last");
    chk({bmem[33], bmem[34], bmem[35]} == 24'h010203, "R5 last slot",
        32'({bmem[33], bmem[34], bmem[35]}), 'h010203);
  endtask

  task automatic t_timing;
    cmd(0, 0, 0, 0, 1, 7, 0);
    bmem[21] = 8'h11; bmem[22] = 8'h22; bmem[23] = 8'h33;
    cmd(1, 0, 1, 0, 0, 0, 0);
    chk(pos_o == 8, "R5 move with read", 32'(pos_o), 8);
    for (int k = 0; k < 3; k++) begin
      chk(mem_en_o && !mem_we_o && busy_o, "R10 read beat", 32'({mem_en_o, mem_we_o, busy_o}), 'b101);
      chk(mem_addr_o == 6'(21 + k), "R5 old position addr", 32'(mem_addr_o), 21 + k);
      @(negedge clk_i);
    end
    chk(!mem_en_o && !done_o && busy_o, "R7 tail", 32'({mem_en_o, done_o, busy_o}), 'b001);
    @(negedge clk_i);
    chk(done_o && !busy_o, "R7 done cycle", 32'({done_o, busy_o}), 'b10);
    chk(rdata_o == 24'h112233, "R6 read timing data", 32'(rdata_o), 'h112233);
    @(negedge clk_i);
    chk(!done_o, "R7 single pulse", 32'(done_o), 0);
    cmd(0, 0, 0, 1, 0, 0, 24'h445566);
    for (int k = 0; k < 3; k++) begin
      chk(mem_en_o && mem_we_o, "R10 write beat", 32'({mem_en_o, mem_we_o}), 'b11);
      chk(mem_addr_o == 6'(24 + k), "R5 write addr", 32'(mem_addr_o), 24 + k);
      @(negedge clk_i);
    end
    chk(!mem_en_o && !mem_we_o, "R10 idle port", 32'({mem_en_o, mem_we_o}), 0);
    @(negedge clk_i);
    chk(done_o, "R7 write done", 32'(done_o), 1);
    @(negedge clk_i);
  endtask

  task automatic t_busy;
    int d0;
    cmd(0, 0, 0, 0, 1, 8, 0);
    d0 = n_done;
    cmd(0, 0, 0, 1, 0, 0, 24'hCAFE01);
    inc_i = 1; dec_i = 0; idx_i = 1; idx_pos_i = 0; rd_i = 1; wr_i = 1; wdata_i = 24'h999999;
    repeat (3) @(negedge clk_i);
    inc_i = 0; idx_i = 0; rd_i = 0; wr_i = 0;
    repeat (10) @(negedge clk_i);
    chk(pos_o == 8, "R4 pos frozen", 32'(pos_o), 8);
    chk(n_done - d0 == 1, "R4 single transaction", n_done - d0, 1);
    chk({bmem[24], bmem[25], bmem[26]} == 24'hCAFE01, "R4 data kept",
        32'({bmem[24], bmem[25], bmem[26]}), 'hCAFE01);
  endtask

  task automatic t_rdwr_hold;
    cmd(0, 0, 0, 0, 1, 4, 0);
    cmd(0, 0, 1, 1, 0, 0, 24'h555555); wait_done("R9 done");
    chk(rdata_o == 24'hA1B2C3, "R9 read wins", 32'(rdata_o), 'hA1B2C3);
    chk(bmem[12] == 8'hA1 && bmem[14] == 8'hC3, "R9 no write",
        32'({bmem[12], bmem[14]}), 'hA1C3);
    cmd(0, 0, 0, 0, 1, 0, 0);
    cmd(0, 0, 0, 1, 0, 0, 24'h778899); wait_done("R8 write done");
    chk(rdata_o == 24'hA1B2C3, "R8 held over write", 32'(rdata_o), 'hA1B2C3);
    cmd(0, 0, 1, 0, 0, 0, 0); wait_done("R8 read done");
    chk(rdata_o == 24'h778899, "R8 updated by read", 32'(rdata_o), 'h778899);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) bmem[i] = 8'(i);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_moves();
    t_write_read();
    t_timing();
    t_busy();
    t_rdwr_hold();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule